// File: doc/BRIEF.md
# EEPROM Erase/Write Cycle Controller

This block runs the self-timed reprogramming of a nonvolatile byte array after a serial-bus front end has collected a complete write request. A one-cycle start pulse hands over a 9-bit word address and an 8-bit data byte. The controller checks the addressed word, runs an erase phase that drives the word to all ones, then runs a write phase that clears the bits whose data bit is zero. Each phase lasts a programmable number of system clocks. A phase is skipped when it would change nothing. The array is modelled as a synthesizable 512 x 8 register file that resets to the erased value. A combinational read port lets the front end fetch bytes for read transfers.

While a cycle runs, the busy output stays high. The front end uses it to withhold its acknowledge to a read-select, and to keep its own sequencer from being reset by the stop that launched the cycle. The front end raises the abort input when it sees a write-select during programming; the cycle then ends at once. A test-pin input turns a particular request into an erase of the whole array. That request is address 0 with data 0xFF while the pin is high.

Top module: `eepc_prog_ctrl`

## Requirements
- R1: After reset busy_o is low and every word reads 0xFF through the read port.
- R2: A start request for a word that is not 0xFF, with data other than 0xFF, sets busy_o on the next cycle. It keeps busy_o high for exactly 2 + ERASE_CYCLES + WRITE_CYCLES cycles, and leaves the word equal to the data byte.
- R3: With data 0xFF the write phase is skipped: busy_o stays high for 2 + ERASE_CYCLES cycles and the word ends at 0xFF.
- R4: When the addressed word already reads 0xFF, the erase phase is skipped: busy_o stays high for 2 + WRITE_CYCLES cycles and the word ends at the data byte.
- R5: When the word is 0xFF and the data is 0xFF, both phases are skipped and busy_o is high for exactly 2 cycles.
- R6: A word changes only at the end of a phase. An abort during the erase phase leaves the old value, and an abort during the write phase leaves 0xFF.
- R7: An abort_i pulse while busy clears busy_o on the next cycle. An abort_i pulse while idle changes neither busy_o nor any word.
- R8: A start request that arrives while busy_o is high is ignored; its address and data never reach the array.
- R9: A request with address 0 and data 0xFF, with test_pin_i high in the start cycle, erases all 512 words to 0xFF and keeps busy_o high for 2 + ERASE_CYCLES cycles. With test_pin_i high and any other address or data, the request behaves as an ordinary single-word request.
- R10: rd_data_o shows the word at rd_addr_i within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a reprogram cycle |
| addr_i | input | 9 | Word address of the request |
| data_i | input | 8 | Data byte of the request |
| test_pin_i | input | 1 | Test-pin level; selects whole-array erase for the 0/0xFF request |
| abort_i | input | 1 | Ends an active cycle at once |
| rd_addr_i | input | 9 | Read-port word address |
| busy_o | output | 1 | High while a cycle is active |
| rd_data_o | output | 8 | Read-port data, combinational from rd_addr_i |

## Verification
The assertions assume that start_i, abort_i and test_pin_i are synchronous to clk_i and are held stable across each rising edge. They also assume that the cycle counts are at least one, so that every phase lasts one clock or more. The stimulus changes inputs only on falling edges and pulses start_i and abort_i for a single cycle. It deliberately sends requests and aborts in states where they must be ignored, so that the guarded paths are exercised without breaking those assumptions.

// File: rtl/eepc_pkg.sv
package eepc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_ERASE = 3'd2,
        ST_WRITE = 3'd3,
        ST_DONE  = 3'd4
    } eepc_state_e;

endpackage

// File: rtl/eepc_array.sv
module eepc_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic              clr_all_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_a_i,
    output logic [DATA_W-1:0] rdata_a_o,
    input  logic [ADDR_W-1:0] raddr_b_i,
    output logic [DATA_W-1:0] rdata_b_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (clr_all_i) begin
                mem_d[i] = '1;
            end else if (we_i && (waddr_i == ADDR_W'(i))) begin
                mem_d[i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_ni) begin
                mem_q[i] <= '1;
            end else begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];

    // R6: a single word write and a whole-array erase never coincide
    p_one_commit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({we_i, clr_all_i}));

    // R9: after a whole-array erase, the word addressed on port B is erased
    p_clear_reads_ones_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_all_i |=> (rdata_b_o == '1));

endmodule

// File: rtl/eepc_timer.sv
module eepc_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (run_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = run_i && (cnt_q == (limit_i - CNT_W'(1)));

    // R2: a running phase never counts beyond its programmed length
    p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !clear_i) |-> (cnt_q < limit_i));

endmodule

// File: rtl/eepc_seq.sv
module eepc_seq
    import eepc_pkg::*;
#(
    parameter int ADDR_W       = 9,
    parameter int DATA_W       = 8,
    parameter int CNT_W        = 8,
    parameter int ERASE_CYCLES = 10,
    parameter int WRITE_CYCLES = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              test_pin_i,
    input  logic              abort_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              tmr_done_i,
    output logic [ADDR_W-1:0] word_addr_o,
    output logic              we_o,
    output logic              clr_all_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              tmr_clear_o,
    output logic              tmr_run_o,
    output logic [CNT_W-1:0]  tmr_limit_o,
    output logic              busy_o
);
    localparam logic [DATA_W-1:0] ONES      = '1;
    localparam logic [CNT_W-1:0]  ERASE_LIM = CNT_W'(ERASE_CYCLES);
    localparam logic [CNT_W-1:0]  WRITE_LIM = CNT_W'(WRITE_CYCLES);

    typedef struct packed {
        eepc_state_e       state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              chip;
    } seq_regs_t;

    seq_regs_t q, d;

    always_comb begin
        d           = q;
        we_o        = 1'b0;
        clr_all_o   = 1'b0;
        wdata_o     = ONES;
        tmr_clear_o = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.addr  = addr_i;
                    d.data  = data_i;
                    d.chip  = test_pin_i && (addr_i == '0) && (data_i == ONES);
                    d.state = ST_CHECK;
                end
            end
            ST_CHECK: begin
                tmr_clear_o = 1'b1;
                if (abort_i) begin
                    d.state = ST_IDLE;
                end else if (q.chip || (word_i != ONES)) begin
                    d.state = ST_ERASE;
                end else if (q.data != ONES) begin
                    d.state = ST_WRITE;
                end else begin
                    d.state = ST_DONE;
                end
            end
            ST_ERASE: begin
                if (abort_i) begin
                    d.state = ST_IDLE;
                end else if (tmr_done_i) begin
                    tmr_clear_o = 1'b1;
                    clr_all_o   = q.chip;
                    we_o        = !q.chip;
                    wdata_o     = ONES;
                    d.state     = (!q.chip && (q.data != ONES)) ? ST_WRITE : ST_DONE;
                end
            end
            ST_WRITE: begin
                if (abort_i) begin
                    d.state = ST_IDLE;
                end else if (tmr_done_i) begin
                    tmr_clear_o = 1'b1;
                    we_o        = 1'b1;
                    wdata_o     = q.data & word_i;
                    d.state     = ST_DONE;
                end
            end
            ST_DONE: begin
                d.state = ST_IDLE;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q.state <= ST_IDLE;
            q.addr  <= '0;
            q.data  <= ONES;
            q.chip  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign word_addr_o = q.addr;
    assign busy_o      = (q.state != ST_IDLE);
    assign tmr_run_o   = (q.state == ST_ERASE) || (q.state == ST_WRITE);
    assign tmr_limit_o = (q.state == ST_WRITE) ? WRITE_LIM : ERASE_LIM;

    // R6: nothing is committed to the array while idle
    p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_IDLE) |-> (!we_o && !clr_all_o));

    // R8: a request seen while busy does not replace the latched address
    p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i) |=> $stable(q.addr));

    // R3: the write phase is never entered with an all-ones data byte
    p_no_blank_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == ST_WRITE) |-> (q.data != ONES));

endmodule

// File: rtl/eepc_prog_ctrl.sv
module eepc_prog_ctrl #(
    parameter int ADDR_W       = 9,
    parameter int DATA_W       = 8,
    parameter int ERASE_CYCLES = 1_250_000,
    parameter int WRITE_CYCLES = 1_250_000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              test_pin_i,
    input  logic              abort_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int MAX_CYC = (ERASE_CYCLES > WRITE_CYCLES) ? ERASE_CYCLES : WRITE_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic              we, clr_all, tmr_clear, tmr_run, tmr_done;
    logic [ADDR_W-1:0] word_addr;
    logic [DATA_W-1:0] wdata, word;
    logic [CNT_W-1:0]  tmr_limit;

    eepc_seq #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .CNT_W       (CNT_W),
        .ERASE_CYCLES(ERASE_CYCLES),
        .WRITE_CYCLES(WRITE_CYCLES)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .addr_i     (addr_i),
        .data_i     (data_i),
        .test_pin_i (test_pin_i),
        .abort_i    (abort_i),
        .word_i     (word),
        .tmr_done_i (tmr_done),
        .word_addr_o(word_addr),
        .we_o       (we),
        .clr_all_o  (clr_all),
        .wdata_o    (wdata),
        .tmr_clear_o(tmr_clear),
        .tmr_run_o  (tmr_run),
        .tmr_limit_o(tmr_limit),
        .busy_o     (busy_o)
    );

    eepc_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clear_i(tmr_clear),
        .run_i  (tmr_run),
        .limit_i(tmr_limit),
        .done_o (tmr_done)
    );

    eepc_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (we),
        .clr_all_i(clr_all),
        .waddr_i  (word_addr),
        .wdata_i  (wdata),
        .raddr_a_i(rd_addr_i),
        .rdata_a_o(rd_data_o),
        .raddr_b_i(word_addr),
        .rdata_b_o(word)
    );

    // R7: an abort while busy ends the cycle on the next edge
    p_abort_ends_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && abort_i) |=> !busy_o);

    // R2: an accepted request raises busy on the next cycle
    p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && start_i) |=> busy_o);

    // R5: even the shortest cycle keeps busy high for two cycles
    p_busy_min_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(busy_o) && !abort_i) |=> busy_o);

    // R7: an abort while idle does not raise busy
    p_idle_abort_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && abort_i && !start_i) |=> !busy_o);

endmodule

// File: tb/eepc_prog_ctrl_tb.sv
module eepc_prog_ctrl_tb;
    localparam int N = 12;
    localparam int M = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, pin = 1'b0, abort = 1'b0;
    logic [8:0] addr = '0, rd_addr = '0;
    logic [7:0] data = '0;
    logic       busy;
    logic [7:0] rd_data;

    int n_cmp = 0, n_bad = 0;
    bit cmp_en = 1'b0;

    always #2 clk = ~clk;

    eepc_prog_ctrl #(.ERASE_CYCLES(N), .WRITE_CYCLES(M)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
        .data_i(data), .test_pin_i(pin), .abort_i(abort),
        .rd_addr_i(rd_addr), .busy_o(busy), .rd_data_o(rd_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // behavioural reference: remaining-time bookkeeping per request
    logic [7:0] m_mem [512];
    bit         m_busy = 1'b0;
    bit         m_chip;
    int         m_k, m_ea, m_wa, m_len;
    logic [8:0] m_a;
    logic [7:0] m_d;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0;
            foreach (m_mem[i]) m_mem[i] = 8'hFF;
        end else if (m_busy) begin
            if (abort) begin
                m_busy = 1'b0;
            end else begin
                m_k++;
                if (m_k == m_ea) begin
                    if (m_chip) foreach (m_mem[i]) m_mem[i] = 8'hFF;
                    else m_mem[m_a] = 8'hFF;
                end
                if (m_k == m_wa) m_mem[m_a] = m_d;
                if (m_k == m_len) m_busy = 1'b0;
            end
        end else if (start) begin
            bit er, wr;
            m_a    = addr;
            m_d    = data;
            m_chip = pin && (addr == 0) && (data == 8'hFF);
            er     = m_chip || (m_mem[addr] != 8'hFF);
            wr     = !m_chip && (data != 8'hFF);
            m_ea   = er ? 1 + N : -1;
            m_wa   = wr ? 1 + (er ? N : 0) + M : -1;
            m_len  = 2 + (er ? N : 0) + (wr ? M : 0);
            m_k    = 0;
            m_busy = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            #1;
            chk("R2 busy against model", busy, m_busy);
            chk("R10 read port against model", rd_data, m_mem[rd_addr]);
        end
    end

    task automatic launch(input logic [8:0] a, input logic [7:0] d, input logic p);
        @(negedge clk);
        start = 1'b1; addr = a; data = d; pin = p;
        @(negedge clk);
        start = 1'b0; pin = 1'b0;
    endtask

    task automatic wait_idle();
        #1;
        while (busy) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic req(input logic [8:0] a, input logic [7:0] d, input logic p,
                       output int n);
        launch(a, d, p);
        #1;
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic rd(input string tag, input logic [8:0] a, input logic [7:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        cmp_en = 1'b1;
        #1;
        chk("R1 busy after reset", busy, 0);
        rd("R1 word 0 erased", 9'd0, 8'hFF);
        rd("R1 word 511 erased", 9'd511, 8'hFF);
        rd("R1 word 100 erased", 9'd100, 8'hFF);

        req(9'd5, 8'h3C, 1'b0, n);
        chk("R4 erase skipped length", n, 2 + M);
        rd("R4 word holds data", 9'd5, 8'h3C);

        req(9'd5, 8'hA5, 1'b0, n);
        chk("R2 full cycle length", n, 2 + N + M);
        rd("R2 word holds new data", 9'd5, 8'hA5);

        req(9'd5, 8'hFF, 1'b0, n);
        chk("R3 write skipped length", n, 2 + N);
        rd("R3 word erased", 9'd5, 8'hFF);

        req(9'd7, 8'hFF, 1'b0, n);
        chk("R5 both skipped length", n, 2);
        rd("R5 word unchanged", 9'd7, 8'hFF);

        req(9'd9, 8'h11, 1'b0, n);
        launch(9'd9, 8'h22, 1'b0);
        repeat (2) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        #1;
        chk("R7 abort clears busy", busy, 0);
        rd("R6 abort in erase keeps old", 9'd9, 8'h11);

        launch(9'd9, 8'h22, 1'b0);
        repeat (N + 3) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        #1;
        chk("R7 abort in write clears busy", busy, 0);
        rd("R6 abort in write leaves erased", 9'd9, 8'hFF);

        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        #1;
        chk("R7 idle abort keeps idle", busy, 0);
        rd("R7 idle abort keeps word", 9'd5, 8'hFF);

        launch(9'd10, 8'h44, 1'b0);
        start = 1'b1; addr = 9'd11; data = 8'h55;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        rd("R8 second request ignored", 9'd11, 8'hFF);
        rd("R8 first request done", 9'd10, 8'h44);

        req(9'd300, 8'h5A, 1'b0, n);
        req(9'd0, 8'hFF, 1'b1, n);
        chk("R9 chip erase length", n, 2 + N);
        rd("R9 word 10 erased", 9'd10, 8'hFF);
        rd("R9 word 300 erased", 9'd300, 8'hFF);

        req(9'd3, 8'h0F, 1'b1, n);
        chk("R9 pin with other request is normal", n, 2 + M);
        rd("R9 single word written", 9'd3, 8'h0F);

        req(9'd0, 8'hFF, 1'b0, n);
        chk("R9 pin low gives ordinary request", n, 2);

        @(negedge clk);
        rd_addr = 9'd3;
        #1;
        chk("R10 same-cycle read a", rd_data, 8'h0F);
        rd_addr = 9'd10;
        #1;
        chk("R10 same-cycle read b", rd_data, 8'hFF);

        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule